// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Sleep and Wakeup

This block is the receive half of an asynchronous serial port, meant for a shared line where many stations listen and most traffic belongs to someone else. It samples the serial line once per bit time, on each pulse of a sample-enable tick from an external baud generator. It turns a frame of 10 or 11 bit times into a parallel data word, an optional ninth bit, and one-cycle status pulses for data received, frame error, parity error and idle line.

A station that has no interest in the current message can put its receiver to sleep. While the receiver sleeps, it still deserializes every frame, but it holds back the data-received, frame-error and parity-error pulses. Idle detection keeps running. A wake-mode bit, captured when sleep is requested, picks the event that ends sleep. In idle mode, that event is a run of idle ones at least one frame long. In address mode, it is a received character whose address bit is 1. In address mode, the character that wakes the receiver is delivered, so the host can compare it with its own station address.

The controlling state machine has three states. HUNT waits for a start bit. PAYLOAD shifts in the data bits and the optional ninth bit. STOP samples the stop-bit position. The transitions are: HUNT to PAYLOAD on a tick that samples 0; PAYLOAD to PAYLOAD on each tick until the last payload bit; PAYLOAD to STOP on the tick of the last payload bit; STOP to HUNT on the next tick. Frame results are registered on the STOP-to-HUNT edge and are visible in the following cycle.

Top module: `async_rx_sleep`

## Requirements
- R1: After reset, the outputs rx_valid, frame_err, parity_err, idle, asleep, rx_data and rx_ninth are all 0.
- R2: frame_fmt selects the frame layout. Code 0 is a start bit, 8 data bits and a stop bit. Code 1 is a start bit, 8 data bits, a ninth (address) bit and a stop bit. Code 2 is a start bit, 8 data bits, a parity bit and a stop bit. rx_valid pulses for one cycle after the edge that samples the stop bit, with rx_data holding the word. rx_ninth holds the ninth bit in codes 1 and 2, and 0 in code 0.
- R3: When msb_first is 1, the data bits arrive with word bit 7 first; otherwise bit 0 arrives first. Either order yields the same rx_data. The ninth bit always comes last, just before the stop bit.
- R4: In code 2, parity_err pulses with rx_valid when the XOR of the 8 data bits, the parity bit and parity_odd is 1; parity_odd=0 means even parity. In codes 0 and 1, parity_err stays 0.
- R5: When the stop-bit position samples 0, frame_err pulses with rx_valid. An all-zero break frame therefore reports a frame error.
- R6: idle pulses once, on the tick that completes a run of consecutive sampled ones after a stop bit that sampled 1. The run is 10 ones for code 0 and 11 for codes 1 and 2. A zero restarts the count. No idle is reported before the first good stop bit after reset, and none is reported again until the next good stop bit.
- R7: A sleep_req pulse sets asleep only while async_mode is 1, and it captures wake_on_addr as the wake mode. With async_mode at 0, the request is ignored.
- R8: While asleep, received frames that do not wake the receiver produce no rx_valid, frame_err or parity_err pulse, but idle still pulses.
- R9: With idle wake mode (wake_on_addr=0), the idle pulse clears asleep on the same edge.
- R10: With address wake mode (wake_on_addr=1), a frame whose address bit is 1 clears asleep and is delivered with rx_valid on the same edge. The address bit is the ninth bit in code 1, and word bit 7 in codes 0 and 2. A frame whose address bit is 0, or an idle run, leaves the receiver asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One pulse per bit time; the line is sampled on these edges |
| rx_line | input | 1 | Serial line, idle high |
| frame_fmt | input | 2 | Frame layout code (0, 1 or 2) |
| msb_first | input | 1 | Data bit order on the line |
| parity_odd | input | 1 | Parity sense for code 2 |
| async_mode | input | 1 | Asynchronous mode selected; enables the sleep function |
| sleep_req | input | 1 | Pulse to put the receiver to sleep |
| wake_on_addr | input | 1 | Wake mode captured at sleep: 0 idle line, 1 address bit |
| rx_data | output | DATA_W | Last delivered data word |
| rx_ninth | output | 1 | Last delivered ninth bit |
| rx_valid | output | 1 | Data-received pulse |
| frame_err | output | 1 | Frame error pulse |
| parity_err | output | 1 | Parity error pulse |
| idle | output | 1 | Idle-line pulse |
| asleep | output | 1 | Receiver is sleeping |

## Verification
The assertions take three things for granted about the inputs. First, sample_tick pulses no more than once per bit time. Second, frame_fmt, msb_first and parity_odd do not change while a frame is in flight. Third, sleep_req is raised only between frames, so a sleep request never arrives on the same edge as a wakeup event. The stimulus keeps within these limits: it spaces ticks two cycles apart, changes the configuration only while the line is idle in HUNT, and pulses sleep_req only after a frame or an idle run has finished.

// File: rtl/async_rx_sleep_pkg.sv
package async_rx_sleep_pkg;

    typedef enum logic [1:0] {
        FMT_PLAIN     = 2'd0,
        FMT_MULTIDROP = 2'd1,
        FMT_PARITY    = 2'd2,
        FMT_SPARE     = 2'd3
    } frame_fmt_e;

    typedef enum logic [1:0] {
        RX_HUNT    = 2'd0,
        RX_PAYLOAD = 2'd1,
        RX_STOP    = 2'd2
    } rx_state_e;

    function automatic logic fmt_has_ninth(input frame_fmt_e f);
        return (f == FMT_MULTIDROP) || (f == FMT_PARITY);
    endfunction

endpackage

// File: rtl/rx_bit_assembler.sv
module rx_bit_assembler #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              msb_first,
    output logic [DATA_W-1:0] word,
    output logic              ninth_bit
);

    // one flop per word bit, each claiming the payload slot that maps to it
    for (genvar g = 0; g < DATA_W; g++) begin : g_word_bit
        localparam logic [IDX_W-1:0] SLOT_LSB = IDX_W'(g);
        localparam logic [IDX_W-1:0] SLOT_MSB = IDX_W'(DATA_W - 1 - g);
        logic hit;
        assign hit = shift_en && (bit_idx == (msb_first ? SLOT_MSB : SLOT_LSB));
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                word[g] <= 1'b0;
            end else if (hit) begin
                word[g] <= bit_in;
            end
        end
    end

    // the ninth bit always sits in the slot right after the data bits
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ninth_bit <= 1'b0;
        end else if (shift_en && bit_idx == IDX_W'(DATA_W)) begin
            ninth_bit <= bit_in;
        end
    end

endmodule

// File: rtl/rx_idle_detect.sv
module rx_idle_detect #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic             hunting,
    input  logic             arm,
    input  logic             disarm,
    input  logic [CNT_W-1:0] need,
    output logic             idle_hit
);

    logic             armed;
    logic [CNT_W-1:0] ones;

    assign idle_hit = armed && hunting && tick && line &&
                      ((ones + CNT_W'(1)) == need);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            ones  <= '0;
        end else if (idle_hit) begin
            armed <= 1'b0;
            ones  <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            ones  <= '0;
        end else if (disarm) begin
            armed <= 1'b0;
            ones  <= '0;
        end else if (!hunting || (tick && !line)) begin
            ones  <= '0;
        end else if (armed && tick) begin
            ones  <= ones + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rx_sleep_ctrl.sv
module rx_sleep_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic async_mode,
    input  logic wake_on_addr,
    input  logic idle_hit,
    input  logic frame_done,
    input  logic addr_bit,
    output logic asleep,
    output logic addr_wake
);

    logic addr_mode_q;
    logic idle_wake;

    assign addr_wake = asleep &&  addr_mode_q && frame_done && addr_bit;
    assign idle_wake = asleep && !addr_mode_q && idle_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep      <= 1'b0;
            addr_mode_q <= 1'b0;
        end else if (addr_wake || idle_wake) begin
            asleep      <= 1'b0;
        end else if (sleep_req && async_mode) begin
            asleep      <= 1'b1;
            addr_mode_q <= wake_on_addr;
        end
    end

endmodule

// File: rtl/async_rx_sleep.sv
module async_rx_sleep
    import async_rx_sleep_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rx_line,
    input  logic [1:0]        frame_fmt,
    input  logic              msb_first,
    input  logic              parity_odd,
    input  logic              async_mode,
    input  logic              sleep_req,
    input  logic              wake_on_addr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ninth,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              parity_err,
    output logic              idle,
    output logic              asleep
);

    localparam int unsigned IDX_W = $clog2(DATA_W + 2);
    localparam int unsigned CNT_W = $clog2(DATA_W + 4);

    frame_fmt_e        fmt;
    logic              ninth_on;
    logic [IDX_W-1:0]  last_idx;
    logic [CNT_W-1:0]  idle_need;

    assign fmt       = frame_fmt_e'(frame_fmt);
    assign ninth_on  = fmt_has_ninth(fmt);
    assign last_idx  = ninth_on ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    assign idle_need = ninth_on ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);

    rx_state_e        state, state_nxt;
    logic [IDX_W-1:0] bit_idx;
    logic             start_seen, take_bit, frame_done;

    assign start_seen = (state == RX_HUNT)    && sample_tick && !rx_line;
    assign take_bit   = (state == RX_PAYLOAD) && sample_tick;
    assign frame_done = (state == RX_STOP)    && sample_tick;

    // state register and payload slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_HUNT;
            bit_idx <= '0;
        end else begin
            state <= state_nxt;
            if (start_seen) begin
                bit_idx <= '0;
            end else if (take_bit) begin
                bit_idx <= bit_idx + IDX_W'(1);
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_HUNT:    if (start_seen) state_nxt = RX_PAYLOAD;
            RX_PAYLOAD: if (take_bit && bit_idx == last_idx) state_nxt = RX_STOP;
            RX_STOP:    if (frame_done) state_nxt = RX_HUNT;
            default:    state_nxt = RX_HUNT;
        endcase
    end

    logic [DATA_W-1:0] word;
    logic              ninth_bit;

    rx_bit_assembler #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_seen),
        .shift_en  (take_bit),
        .bit_in    (rx_line),
        .bit_idx   (bit_idx),
        .msb_first (msb_first),
        .word      (word),
        .ninth_bit (ninth_bit)
    );

    logic idle_hit;

    rx_idle_detect #(
        .CNT_W (CNT_W)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .line     (rx_line),
        .hunting  (state == RX_HUNT),
        .arm      (frame_done && rx_line),
        .disarm   (start_seen),
        .need     (idle_need),
        .idle_hit (idle_hit)
    );

    logic addr_bit, addr_wake, parity_bad, deliver;

    assign addr_bit   = (fmt == FMT_MULTIDROP) ? ninth_bit : word[DATA_W-1];
    assign parity_bad = (fmt == FMT_PARITY) && (^{word, ninth_bit, parity_odd});

    rx_sleep_ctrl u_sleep (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .async_mode   (async_mode),
        .wake_on_addr (wake_on_addr),
        .idle_hit     (idle_hit),
        .frame_done   (frame_done),
        .addr_bit     (addr_bit),
        .asleep       (asleep),
        .addr_wake    (addr_wake)
    );

    assign deliver = frame_done && (!asleep || addr_wake);

    // registered results and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_ninth   <= 1'b0;
            rx_valid   <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
            idle       <= 1'b0;
        end else begin
            rx_valid   <= deliver;
            frame_err  <= deliver && !rx_line;
            parity_err <= deliver && parity_bad;
            idle       <= idle_hit;
            if (deliver) begin
                rx_data  <= word;
                rx_ninth <= ninth_on && ninth_bit;
            end
        end
    end

endmodule

// File: rtl/async_rx_sleep_chk.sv
module async_rx_sleep_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic async_mode,
    input logic rx_valid,
    input logic frame_err,
    input logic parity_err,
    input logic idle,
    input logic asleep
);

    assert_frame_err_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> rx_valid);

    assert_parity_err_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> rx_valid);

    assert_valid_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_idle_not_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !rx_valid);

    assert_sleep_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(sleep_req && async_mode));

    assert_no_delivery_while_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(asleep)) |-> !asleep);

    assert_wake_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> (idle || rx_valid));

    assert_addr_wake_delivers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep) && !idle) |-> rx_valid);

endmodule

bind async_rx_sleep async_rx_sleep_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .async_mode (async_mode),
    .rx_valid   (rx_valid),
    .frame_err  (frame_err),
    .parity_err (parity_err),
    .idle       (idle),
    .asleep     (asleep)
);

// File: tb/async_rx_sleep_tb.sv
`timescale 1ns/1ps
module async_rx_sleep_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] frame_fmt = 2'd0;
    logic       msb_first = 1'b0;
    logic       parity_odd = 1'b0;
    logic       async_mode = 1'b1;
    logic       sleep_req = 1'b0;
    logic       wake_on_addr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ninth, rx_valid, frame_err, parity_err, idle, asleep;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    async_rx_sleep #(.DATA_W(8)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_tick  (sample_tick),
        .rx_line      (rx_line),
        .frame_fmt    (frame_fmt),
        .msb_first    (msb_first),
        .parity_odd   (parity_odd),
        .async_mode   (async_mode),
        .sleep_req    (sleep_req),
        .wake_on_addr (wake_on_addr),
        .rx_data      (rx_data),
        .rx_ninth     (rx_ninth),
        .rx_valid     (rx_valid),
        .frame_err    (frame_err),
        .parity_err   (parity_err),
        .idle         (idle),
        .asleep       (asleep)
    );

    // {fmt[1:0], msb_first, parity_odd, data[7:0], ninth, stop}
    localparam int NVEC = 10;
    localparam logic [13:0] VECS [NVEC] = '{
        {2'd0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1},
        {2'd0, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1},
        {2'd1, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b1},
        {2'd1, 1'b1, 1'b0, 8'hC3, 1'b0, 1'b1},
        {2'd2, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1},
        {2'd2, 1'b0, 1'b0, 8'h97, 1'b0, 1'b1},
        {2'd2, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b1},
        {2'd2, 1'b1, 1'b1, 8'hF0, 1'b0, 1'b1},
        {2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_line = 1'b1;
        sample_tick = 1'b0;
        sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one bit time; returns at the negedge after the sampling edge
    task automatic tick_bit(input logic b);
        @(negedge clk);
        rx_line = b;
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic ninth, input logic stop);
        tick_bit(1'b0);
        for (int i = 0; i < 8; i++) tick_bit(msb_first ? d[7-i] : d[i]);
        if (frame_fmt != 2'd0) tick_bit(ninth);
        tick_bit(stop);
    endtask

    // send n ones and count idle pulses seen
    task automatic send_ones(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick_bit(1'b1);
            if (idle) pulses++;
        end
    endtask

    task automatic go_sleep(input logic am, input logic wa);
        @(negedge clk);
        async_mode = am;
        wake_on_addr = wa;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1", "rx_valid", rx_valid, 0);
        chk("R1", "frame_err", frame_err, 0);
        chk("R1", "parity_err", parity_err, 0);
        chk("R1", "idle", idle, 0);
        chk("R1", "asleep", asleep, 0);
        chk("R1", "rx_data", rx_data, 0);
        chk("R1", "rx_ninth", rx_ninth, 0);

        // R6: no idle before the first good stop bit
        send_ones(13, p);
        chk("R6", "idle before arming", p, 0);

        // vector table: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            logic [13:0] e;
            logic exp_par;
            e = VECS[v];
            frame_fmt  = e[13:12];
            msb_first  = e[11];
            parity_odd = e[10];
            send_frame(e[9:2], e[1], e[0]);
            exp_par = (e[13:12] == 2'd2) && (^{e[9:2], e[1], e[10]});
            chk("R2", "rx_valid", rx_valid, 1);
            chk("R3", "rx_data", rx_data, e[9:2]);
            chk("R2", "rx_ninth", rx_ninth, (e[13:12] != 2'd0) ? e[1] : 1'b0);
            chk("R4", "parity_err", parity_err, exp_par);
            chk("R5", "frame_err", frame_err, !e[0]);
            tick_bit(1'b1);
            tick_bit(1'b1);
        end

        // R6: idle run length per format, single pulse per arming
        frame_fmt = 2'd0; msb_first = 1'b0;
        send_frame(8'h11, 1'b0, 1'b1);
        send_ones(9, p);
        chk("R6", "idle after 9 ones fmt0", p, 0);
        tick_bit(1'b1);
        chk("R6", "idle on 10th one fmt0", idle, 1);
        send_ones(14, p);
        chk("R6", "no second idle", p, 0);
        frame_fmt = 2'd1;
        send_frame(8'h22, 1'b0, 1'b1);
        send_ones(10, p);
        chk("R6", "idle after 10 ones fmt1", p, 0);
        tick_bit(1'b1);
        chk("R6", "idle on 11th one fmt1", idle, 1);
        // a zero (start bit) restarts the run
        frame_fmt = 2'd0;
        send_frame(8'h33, 1'b0, 1'b1);
        send_ones(6, p);
        send_frame(8'h44, 1'b0, 1'b1);
        chk("R6", "frame after partial run", rx_valid, 1);
        send_ones(9, p);
        chk("R6", "run restarted", p, 0);
        tick_bit(1'b1);
        chk("R6", "idle after restart", idle, 1);

        // R7: sleep request gated by async_mode
        go_sleep(1'b0, 1'b0);
        chk("R7", "ignored without async", asleep, 0);
        go_sleep(1'b1, 1'b0);
        chk("R7", "asleep set", asleep, 1);

        // R8 / R9: idle wake mode
        send_frame(8'h55, 1'b0, 1'b0);
        chk("R8", "frame_err suppressed", frame_err, 0);
        chk("R8", "valid suppressed (bad stop)", rx_valid, 0);
        tick_bit(1'b1);
        send_frame(8'hF5, 1'b0, 1'b1);
        chk("R8", "valid suppressed", rx_valid, 0);
        chk("R8", "still asleep", asleep, 1);
        frame_fmt = 2'd2;
        send_frame(8'h01, 1'b0, 1'b1);
        chk("R8", "parity_err suppressed", parity_err, 0);
        frame_fmt = 2'd0;
        send_frame(8'h66, 1'b0, 1'b1);
        send_ones(9, p);
        chk("R9", "asleep before run completes", asleep, 1);
        tick_bit(1'b1);
        chk("R9", "idle pulses while asleep", idle, 1);
        chk("R9", "woken by idle", asleep, 0);
        send_frame(8'h77, 1'b0, 1'b1);
        chk("R9", "delivery after wake", rx_valid, 1);

        // R10: address wake mode, fmt0 address is word bit 7
        go_sleep(1'b1, 1'b1);
        send_frame(8'h12, 1'b0, 1'b1);
        chk("R10", "addr 0 no wake", asleep, 1);
        chk("R10", "addr 0 no valid", rx_valid, 0);
        send_ones(10, p);
        chk("R10", "idle seen", p, 1);
        chk("R10", "idle does not wake", asleep, 1);
        msb_first = 1'b1;
        send_frame(8'h85, 1'b0, 1'b1);
        chk("R10", "address frame wakes", asleep, 0);
        chk("R10", "address frame valid", rx_valid, 1);
        chk("R10", "address frame data", rx_data, 8'h85);
        // fmt1: address is the ninth bit
        tick_bit(1'b1);
        frame_fmt = 2'd1; msb_first = 1'b0;
        go_sleep(1'b1, 1'b1);
        send_frame(8'hFF, 1'b0, 1'b1);
        chk("R10", "fmt1 bit7 not address", asleep, 1);
        send_frame(8'h03, 1'b1, 1'b1);
        chk("R10", "fmt1 ninth wakes", asleep, 0);
        chk("R10", "fmt1 ninth delivered", rx_ninth, 1);
        // fmt2: address is word bit 7
        tick_bit(1'b1);
        frame_fmt = 2'd2; parity_odd = 1'b0;
        go_sleep(1'b1, 1'b1);
        send_frame(8'h7F, 1'b1, 1'b1);
        chk("R10", "fmt2 parity bit not address", asleep, 1);
        send_frame(8'h80, 1'b1, 1'b1);
        chk("R10", "fmt2 bit7 wakes", asleep, 0);
        chk("R10", "fmt2 wake data", rx_data, 8'h80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule